// File: doc/BRIEF.md
# Addressed Command Register Interface

This block sits on the device side of a shared 8-bit peripheral bus. Up to eight such devices can share that bus. The host runs a bus cycle by pulling `cs_n` low, with `rw` (1 = read) and `a1` held steady for as long as `cs_n` stays low. A host write with `a1` = 0 is a command byte. Its top three bits carry a device number, and each device compares that number with its own strapped `strap_id`. The device that matches becomes selected, and the low bits of the command byte load its mode register. Any other device drops out and ignores all traffic until a command byte names it again.

While selected, a read with `a1` = 0 returns the mode register. A read or write with `a1` = 1 reaches one of three data registers, picked by a 2-bit field in the mode register. An interrupt flag drives a shared, pulled-up request line, and it only ever pulls that line low. The flag is set when a bus cycle to the selected device ends, or when the device core signals that a transfer is finished. Every mode-register access clears it. An enable bit, which reset clears, keeps the flag cleared whenever the enable is off.

Inputs are synchronous to `clk`. An access begins on the first clock edge at which `cs_n` is sampled low, and it ends on the first edge at which `cs_n` is sampled high again.

Top module: `addr_cmd_if`

## Requirements
- R1: After reset the device is deselected, the mode register and all three data registers hold 0, `bus_oe` is 0, `bus_dout` is 8'h00 and `irq_drive` is 0.
- R2: A write with `a1`=0 whose bits 7:5 equal `strap_id` selects the device and loads bits 3:0 into the mode register. In the mode register, bit 0 is the enable, bit 1 is the per-byte interrupt enable and bits 3:2 are the register select. Command bit 4 is ignored.
- R3: A write with `a1`=0 whose bits 7:5 differ from `strap_id` deselects the device. Until the next matching command, the device drives no read and `a1`=1 writes leave the data registers unchanged.
- R4: A write with `a1`=1 to the selected device loads the data register numbered by the register select (0, 1 or 2). Select value 3 names no register: writes to it have no effect and reads from it return 8'h00.
- R5: A read with `a1`=0 from the selected device returns {`strap_id`, 1'b0, mode[3:0]}.
- R6: `bus_oe` is 1 exactly while `cs_n`=0, `rw`=1 and the device is selected. `bus_dout` is 8'h00 whenever `bus_oe` is 0. Both follow the inputs with no clock delay.
- R7: A mode-register access clears the interrupt flag at its first clock edge. This covers a matching command byte, and a read with `a1`=0 by the selected device.
- R8: When the enable and the per-byte interrupt enable are both 1, the end of any access by the device (selected after that access) sets the flag one edge after `cs_n` is sampled high.
- R9: A one-cycle `xfer_done` pulse sets the flag when the enable is 1. If it coincides with a clearing access, the set takes priority.
- R10: While the enable is 0 the flag is held at 0 from the next edge on. `irq_drive`=1 means "pull the shared request line low".
- R11: `rst_n` low clears all state at once, without waiting for a clock. Release is synchronised, so the block acts on bus inputs from the third rising edge after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_id | input | 3 | Device number this block answers to |
| cs_n | input | 1 | Active-low bus cycle select |
| rw | input | 1 | 1 = host read, 0 = host write |
| a1 | input | 1 | 0 = command/mode, 1 = data register |
| bus_din | input | 8 | Data written by the host |
| xfer_done | input | 1 | One-cycle transfer-complete pulse from the device core |
| bus_dout | output | 8 | Read data, 8'h00 when not driving |
| bus_oe | output | 1 | Drive enable for `bus_dout` |
| irq_drive | output | 1 | 1 = pull the shared request line low |

## Verification
Read data and `bus_oe` are combinational, so they are due in the same cycle that `cs_n`, `rw` and `a1` are applied. Register and mode writes land at the first edge with `cs_n` low. Flag clears land at that same edge. Flag sets land at the edge after `cs_n` returns high, or at the edge after `xfer_done`. The bench drives inputs at falling edges and samples outputs 1 ns later. Its behavioural model advances on the same rising edges, so every comparison sees exactly the state the requirements predict for that cycle. Directed checks add the coincident set/clear case and an asynchronous reset applied between clock edges.

// File: rtl/aci_pkg.sv
`timescale 1ns/1ps
package aci_pkg;
  localparam int unsigned MODE_W  = 4;
  localparam int unsigned RSEL_W  = 2;
  localparam int unsigned NUM_DREG = 3;

  typedef struct packed {
    logic [RSEL_W-1:0] rsel;
    logic              byte_irq;
    logic              en;
  } mode_t;
endpackage

// File: rtl/aci_rst_sync.sv
`timescale 1ns/1ps
module aci_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_int_n = sync_q[STAGES-1];
endmodule

// File: rtl/aci_bus_front.sv
`timescale 1ns/1ps
module aci_bus_front #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ID_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rw,
  input  logic              a1,
  input  logic [DATA_W-1:0] din,
  input  logic [ID_W-1:0]   strap_id,
  output logic              acc_start,
  output logic              acc_end,
  output logic              cmd_hit,
  output logic              mode_touch,
  output logic              data_wr,
  output logic              byte_done,
  output logic              selected
);
  logic            cs_q;
  logic            sel_q;
  logic            sel_d;
  logic            cmd_wr;
  logic [ID_W-1:0] id_field;

  always_comb begin
    acc_start = cs_q & ~cs_n;
    acc_end   = ~cs_q & cs_n;
    id_field  = din[DATA_W-1 -: ID_W];
    cmd_wr    = acc_start & ~a1 & ~rw;
    cmd_hit   = cmd_wr & (id_field == strap_id);
    sel_d     = cmd_wr ? cmd_hit : sel_q;
    mode_touch = cmd_hit | (acc_start & ~a1 & rw & sel_q);
    data_wr   = acc_start & a1 & ~rw & sel_q;
    byte_done = acc_end & sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q  <= 1'b1;
      sel_q <= 1'b0;
    end else begin
      cs_q  <= cs_n;
      sel_q <= sel_d;
    end
  end

  assign selected = sel_q;
endmodule

// File: rtl/aci_regs.sv
`timescale 1ns/1ps
module aci_regs
  import aci_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ID_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_hit,
  input  logic              data_wr,
  input  logic              a1,
  input  logic [DATA_W-1:0] din,
  input  logic [ID_W-1:0]   strap_id,
  output mode_t             mode,
  output logic [DATA_W-1:0] rd_data
);
  localparam int unsigned PAD_W = DATA_W - ID_W - MODE_W;

  mode_t             mode_q;
  mode_t             mode_d;
  logic [DATA_W-1:0] dreg_q [NUM_DREG];
  logic [DATA_W-1:0] dsel_data;

  always_comb begin
    mode_d = mode_q;
    if (cmd_hit) mode_d = mode_t'(din[MODE_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else        mode_q <= mode_d;
  end

  for (genvar g = 0; g < NUM_DREG; g++) begin : g_dreg
    logic              wr_en;
    logic [DATA_W-1:0] nxt;
    always_comb begin
      wr_en = data_wr && (mode_q.rsel == RSEL_W'(g));
      nxt   = wr_en ? din : dreg_q[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dreg_q[g] <= '0;
      else        dreg_q[g] <= nxt;
    end
  end

  always_comb begin
    dsel_data = '0;
    for (int i = 0; i < NUM_DREG; i++) begin
      if (mode_q.rsel == RSEL_W'(i)) dsel_data = dreg_q[i];
    end
    rd_data = a1 ? dsel_data : {strap_id, {PAD_W{1'b0}}, mode_q};
  end

  assign mode = mode_q;
endmodule

// File: rtl/aci_irq.sv
`timescale 1ns/1ps
module aci_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic byte_irq,
  input  logic byte_done,
  input  logic xfer_done,
  input  logic clr,
  output logic irq_drive
);
  logic flag_q;
  logic flag_d;
  logic set_req;

  always_comb begin
    set_req = xfer_done | (byte_done & byte_irq);
    if (!en)          flag_d = 1'b0;
    else if (set_req) flag_d = 1'b1;
    else if (clr)     flag_d = 1'b0;
    else              flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign irq_drive = flag_q;
endmodule

// File: rtl/addr_cmd_if.sv
`timescale 1ns/1ps
module addr_cmd_if
  import aci_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ID_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   strap_id,
  input  logic              cs_n,
  input  logic              rw,
  input  logic              a1,
  input  logic [DATA_W-1:0] bus_din,
  input  logic              xfer_done,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_oe,
  output logic              irq_drive
);
  logic              rst_int_n;
  logic              acc_start;
  logic              acc_end;
  logic              cmd_hit;
  logic              mode_touch;
  logic              data_wr;
  logic              byte_done;
  logic              selected;
  mode_t             mode;
  logic [DATA_W-1:0] rd_data;

  aci_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_int_n(rst_int_n)
  );

  aci_bus_front #(.DATA_W(DATA_W), .ID_W(ID_W)) u_front (
    .clk(clk), .rst_n(rst_int_n), .cs_n(cs_n), .rw(rw), .a1(a1),
    .din(bus_din), .strap_id(strap_id), .acc_start(acc_start),
    .acc_end(acc_end), .cmd_hit(cmd_hit), .mode_touch(mode_touch),
    .data_wr(data_wr), .byte_done(byte_done), .selected(selected)
  );

  aci_regs #(.DATA_W(DATA_W), .ID_W(ID_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .cmd_hit(cmd_hit), .data_wr(data_wr),
    .a1(a1), .din(bus_din), .strap_id(strap_id), .mode(mode),
    .rd_data(rd_data)
  );

  aci_irq u_irq (
    .clk(clk), .rst_n(rst_int_n), .en(mode.en), .byte_irq(mode.byte_irq),
    .byte_done(byte_done), .xfer_done(xfer_done), .clr(mode_touch),
    .irq_drive(irq_drive)
  );

  always_comb begin
    bus_oe   = ~cs_n & rw & selected;
    bus_dout = bus_oe ? rd_data : '0;
  end
endmodule

// File: rtl/aci_checker.sv
`timescale 1ns/1ps
module aci_checker #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ID_W   = 3
) (
  input logic              clk,
  input logic              rst_int_n,
  input logic [ID_W-1:0]   strap_id,
  input logic              cs_n,
  input logic              rw,
  input logic              a1,
  input logic [DATA_W-1:0] bus_din,
  input logic              xfer_done,
  input logic [DATA_W-1:0] bus_dout,
  input logic              bus_oe,
  input logic              irq_drive,
  input logic              selected,
  input logic              acc_start,
  input logic [3:0]        mode_bits
);
  // R6: no drive outside a selected read cycle
  a_r6_quiet_bus: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cs_n || !rw) |-> (!bus_oe && bus_dout == '0));

  // R3: a deselected device never drives
  a_r3_deselected_silent: assert property (@(posedge clk) disable iff (!rst_int_n)
    !selected |-> !bus_oe);

  // R4: select value 3 reads as zero
  a_r4_empty_slot: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_oe && a1 && mode_bits[3:2] == 2'b11) |-> bus_dout == '0);

  // R2: mode changes only through a command byte
  a_r2_mode_by_cmd: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(acc_start && !a1 && !rw) |=> $stable(mode_bits));

  // R7: a mode access clears the flag
  a_r7_mode_clears: assert property (@(posedge clk) disable iff (!rst_int_n)
    (acc_start && !a1 && !xfer_done &&
     ((!rw && bus_din[DATA_W-1 -: ID_W] == strap_id) || (rw && selected)))
    |=> !irq_drive);

  // R8: end of access raises the flag when both enables are on
  a_r8_byte_irq: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($rose(cs_n) && selected && mode_bits[0] && mode_bits[1]) |=> irq_drive);

  // R9: transfer-complete pulse raises the flag
  a_r9_xfer_sets: assert property (@(posedge clk) disable iff (!rst_int_n)
    (xfer_done && mode_bits[0]) |=> irq_drive);

  // R10: disabled means no request
  a_r10_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_int_n)
    !mode_bits[0] |=> !irq_drive);
endmodule

bind addr_cmd_if aci_checker #(.DATA_W(DATA_W), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst_int_n(rst_int_n), .strap_id(strap_id), .cs_n(cs_n),
  .rw(rw), .a1(a1), .bus_din(bus_din), .xfer_done(xfer_done),
  .bus_dout(bus_dout), .bus_oe(bus_oe), .irq_drive(irq_drive),
  .selected(selected), .acc_start(acc_start), .mode_bits(mode)
);

// File: tb/addr_cmd_if_tb.sv
`timescale 1ns/1ps
module addr_cmd_if_tb;
  localparam logic [2:0] MY_ID = 3'd5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] strap_id = MY_ID;
  logic       cs_n = 1'b1;
  logic       rw = 1'b1;
  logic       a1 = 1'b0;
  logic [7:0] bus_din = 8'h00;
  logic       xfer_done = 1'b0;
  logic [7:0] bus_dout;
  logic       bus_oe;
  logic       irq_drive;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  addr_cmd_if u_dut (
    .clk(clk), .rst_n(rst_n), .strap_id(strap_id), .cs_n(cs_n), .rw(rw),
    .a1(a1), .bus_din(bus_din), .xfer_done(xfer_done), .bus_dout(bus_dout),
    .bus_oe(bus_oe), .irq_drive(irq_drive)
  );

  // behavioural reference model
  bit       m_sel, m_flag, m_prev_cs;
  bit [3:0] m_mode;
  int       m_regs [3];
  int       m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sel = 0; m_flag = 0; m_prev_cs = 1; m_mode = 0; m_cnt = 0;
      foreach (m_regs[i]) m_regs[i] = 0;
    end else if (m_cnt < 2) begin
      m_cnt++;
    end else begin
      bit start, fin, clear, setf, was_sel, en, bi;
      int slot;
      start = m_prev_cs && !cs_n;
      fin   = !m_prev_cs && cs_n;
      was_sel = m_sel;
      en = m_mode[0]; bi = m_mode[1]; slot = m_mode[3:2];
      clear = 0;
      if (start && !a1 && !rw) begin
        if (bus_din[7:5] == strap_id) begin
          m_sel = 1; clear = 1; m_mode = bus_din[3:0];
        end else m_sel = 0;
      end
      if (start && !a1 && rw && was_sel) clear = 1;
      if (start && a1 && !rw && was_sel && slot < 3) m_regs[slot] = bus_din;
      setf = xfer_done || (fin && was_sel && bi);
      if (!en) m_flag = 0;
      else if (setf) m_flag = 1;
      else if (clear) m_flag = 0;
      m_prev_cs = cs_n;
    end
  end

  function automatic logic [7:0] exp_dout();
    if (!(!cs_n && rw && m_sel)) return 8'h00;
    if (!a1) return {strap_id, 1'b0, m_mode};
    if (m_mode[3:2] == 2'd3) return 8'h00;
    return 8'(m_regs[m_mode[3:2]]);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (!done && rst_n) begin
      check("R6 bus_oe", bus_oe, (!cs_n && rw && m_sel));
      check("R4/R5 bus_dout", bus_dout, exp_dout());
      check("R7-R10 irq_drive", irq_drive, m_flag);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input bit addr, input logic [7:0] d, input bit with_done = 0);
    @(negedge clk);
    cs_n = 0; rw = 0; a1 = addr; bus_din = d; xfer_done = with_done;
    @(negedge clk);
    xfer_done = 0;
    idle(1);
    cs_n = 1; rw = 1;
    idle(1);
  endtask

  task automatic bus_rd(input bit addr, output logic [7:0] d, output logic oe,
                        output logic irq_mid);
    @(negedge clk);
    cs_n = 0; rw = 1; a1 = addr;
    @(negedge clk); #1;
    d = bus_dout; oe = bus_oe; irq_mid = irq_drive;
    @(negedge clk);
    cs_n = 1;
    idle(1);
  endtask

  task automatic pulse_done();
    @(negedge clk); xfer_done = 1;
    @(negedge clk); xfer_done = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic oe, irqm;
    idle(3);
    rst_n = 1;
    idle(4);
    #1;
    // R1 reset state
    check("R1 oe", bus_oe, 0);
    check("R1 dout", bus_dout, 0);
    check("R1 irq", irq_drive, 0);
    bus_rd(0, d, oe, irqm);
    check("R1 unselected read oe", oe, 0);

    // R2 select and mode load (en=1, rsel=0); bit4 ignored
    bus_wr(0, 8'hB1);
    bus_rd(0, d, oe, irqm);
    check("R5 mode readback", d, 8'hA1);
    check("R2 selected", oe, 1);

    // R4 data registers
    bus_wr(1, 8'h3C);
    bus_wr(0, 8'hA5); bus_wr(1, 8'h5A);
    bus_wr(0, 8'hA9); bus_wr(1, 8'hC3);
    bus_wr(0, 8'hAD); bus_wr(1, 8'hFF);
    bus_rd(1, d, oe, irqm);
    check("R4 slot3 reads zero", d, 8'h00);
    bus_wr(0, 8'hA1); bus_rd(1, d, oe, irqm);
    check("R4 reg0", d, 8'h3C);
    bus_wr(0, 8'hA5); bus_rd(1, d, oe, irqm);
    check("R4 reg1", d, 8'h5A);
    bus_wr(0, 8'hA9); bus_rd(1, d, oe, irqm);
    check("R4 reg2 unchanged by slot3 write", d, 8'hC3);

    // R8 per-byte interrupt
    bus_wr(0, 8'hA3);
    #1 check("R8 irq after command", irq_drive, 1);
    bus_rd(0, d, oe, irqm);
    check("R7 cleared during mode read", irqm, 0);
    #1 check("R8 set at end of read", irq_drive, 1);
    bus_wr(0, 8'hA1);
    #1 check("R7 command clears, no set", irq_drive, 0);

    // R9 transfer done, and priority over clear
    pulse_done(); #1;
    check("R9 xfer sets", irq_drive, 1);
    bus_wr(0, 8'hA1, 1);
    #1 check("R9 set wins over clear", irq_drive, 1);

    // R10 disabled
    bus_wr(0, 8'hA0);
    pulse_done(); idle(1); #1;
    check("R10 disabled holds clear", irq_drive, 0);

    // R3 deselect by foreign id
    bus_wr(0, 8'hA1);
    bus_wr(0, 8'h41);
    bus_wr(1, 8'h77);
    bus_rd(1, d, oe, irqm);
    check("R3 deselected no drive", oe, 0);
    bus_wr(0, 8'hA1);
    bus_rd(1, d, oe, irqm);
    check("R3 reg0 kept", d, 8'h3C);

    // R11 asynchronous reset between edges
    pulse_done();
    @(negedge clk); #1;
    check("R11 flag set before reset", irq_drive, 1);
    rst_n = 0; #0.5;
    check("R11 async clear irq", irq_drive, 0);
    idle(2);
    rst_n = 1;
    idle(4);
    bus_rd(0, d, oe, irqm);
    check("R11 deselected after reset", oe, 0);

    idle(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule